// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block sits on the core side of a coprocessor port. It executes five kinds of coprocessor instruction: moving a core register to the coprocessor, reading a coprocessor register back, a coprocessor-internal data operation, and multi-word load and store between memory and the coprocessor. For each instruction it presents a phase code to the coprocessor and reads back a two-bit answer in the same cycle. While the coprocessor answers busy, it keeps polling. For the load and store forms it issues word accesses to memory. When the instruction ends, it reports one outcome code: completed, undefined instruction, coprocessor abort, data abort, or abandoned because an interrupt was pending.

Commands arrive on a valid/ready stream. `cmd_ready` is high only while the sequencer is idle, and a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Memory accesses use a request/ready handshake. The sequencer holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until a cycle in which `mem_ready` is high. Read data and the abort flag are valid in that same accepting cycle. The outcome appears as a one-cycle pulse on `res_valid`. Taking the exception is left to the surrounding core.

Top module: `cop_seq`

## Requirements
- R1: If the bit of `access_mask` selected by the command's coprocessor number is clear, the sequencer raises `res_valid` with `res_code` 1 (undefined) in the cycle after acceptance. In that case it never asserts `cp_valid` or `mem_req`.
- R2: The first coprocessor query of a permitted command uses phase 0 (first). Each answer of 1 (busy) to a phase 0 or phase 1 query is followed by exactly one idle cycle (`cyc_kind` 1) and then a query with phase 1 (busy). On a register write, `cp_wdata` carries the command's `cmd_wdata`.
- R3: If an interrupt is pending during that idle cycle, the sequencer sends one query with phase 2 (interrupt). The next cycle it reports `res_code` 4 with `res_rdata` 0 and sends no further queries.
- R4: The interrupt source is chosen in priority order, and `res_src` reports it. Low `ext_rst_n` comes first (code 1). Next is low `fiq_n` with `fiq_mask` clear (code 2). Last is low `irq_n` with `irq_mask` clear (code 3). With none of these, no interrupt is pending and the instruction continues.
- R5: An answer of 2 (cannot) produces `res_code` 1 for op 0 (to coprocessor), op 1 (from coprocessor) and op 2 (data operation). For op 3 (load) and op 4 (store) it produces `res_code` 2. In every case no memory access is made.
- R6: Load (op 3) sends one phase 3 (transfer) query and then reads memory at the command address. It passes that word on `cp_wdata` in a phase 4 (data) query. As long as the answer is 3 (increment), the address steps by 4 and the read and data query repeat.
- R7: Store (op 4) sends a phase 4 query, takes `cp_rdata` as the word, and writes it to memory. As long as that query's answer was 3, the address steps by 4 and another word is fetched and written.
- R8: A load or store whose address has any bit at or above position LEGAL_BITS (26 by default) set ends with `res_code` 3. So does a store whose address is below VEC_BYTES (32). In both cases all the words are still transferred.
- R9: If `mem_abort` is high on the accepting cycle of any word of a load or store, the instruction ends with `res_code` 3.
- R10: A completed register read costs one coprocessor cycle (`cyc_kind` 2) followed by one idle cycle, and returns the coprocessor's `cp_rdata` on `res_rdata`. A completed register write costs one coprocessor cycle. A data operation costs neither. Every other outcome reports `res_rdata` 0.
- R11: A memory request not yet accepted stays asserted with the same address, direction and data. `cmd_ready` is high only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command taken |
| cmd_op | input | 3 | 0 to-cp, 1 from-cp, 2 data op, 3 load, 4 store |
| cmd_cpnum | input | 4 | Coprocessor number |
| cmd_addr | input | 32 | Start address for load/store |
| cmd_wdata | input | 32 | Register value for a to-cp transfer |
| access_mask | input | 16 | One permit bit per coprocessor |
| ext_rst_n | input | 1 | Core reset request, active low |
| fiq_n | input | 1 | Fast interrupt request, active low |
| irq_n | input | 1 | Normal interrupt request, active low |
| fiq_mask | input | 1 | Fast interrupt disabled |
| irq_mask | input | 1 | Normal interrupt disabled |
| cp_valid | output | 1 | Query to the coprocessor this cycle |
| cp_phase | output | 3 | 0 first, 1 busy, 2 interrupt, 3 transfer, 4 data |
| cp_num | output | 4 | Coprocessor addressed |
| cp_wdata | output | 32 | Register value or loaded word |
| cp_resp | input | 2 | 0 ready, 1 busy, 2 cannot, 3 increment |
| cp_rdata | input | 32 | Register value or store word from coprocessor |
| mem_req | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, valid when accepted |
| mem_abort | input | 1 | Access faulted, valid when accepted |
| cyc_kind | output | 2 | 0 none, 1 idle, 2 coprocessor, 3 memory |
| res_valid | output | 1 | Outcome pulse |
| res_code | output | 3 | 0 ok, 1 undefined, 2 cp abort, 3 data abort, 4 interrupted |
| res_src | output | 2 | Interrupt source when code is 4 |
| res_rdata | output | 32 | Register read result |

## Verification
The bench sweeps every operation over several busy-retry counts, both final answers and several increment counts, with memory stalls of varying length. It then walks all 32 combinations of the interrupt lines and masks. One kind of fault is a polling loop that drops or doubles the idle cycle, or reuses the first phase on retries; the bench sees this as a wrong count of busy-phase queries or idle cycles. An arbitration fault that ignores a mask or misorders reset, fast and normal interrupts returns the wrong source code, or finishes an instruction that should have been abandoned. Faults in the load/store loop show up as a wrong word count, a wrong address step, data not bound to the matching word, a lost memory-abort or vector-area abort, or a request that moves while stalled.

// File: rtl/cop_seq_pkg.sv
package cop_seq_pkg;
  typedef enum logic [2:0] {
    OP_TO_CP = 3'd0, OP_FROM_CP = 3'd1, OP_DATA = 3'd2, OP_LOAD = 3'd3, OP_STORE = 3'd4
  } op_e;
  typedef enum logic [2:0] {
    PH_FIRST = 3'd0, PH_BUSY = 3'd1, PH_INT = 3'd2, PH_XFER = 3'd3, PH_DATA = 3'd4
  } phase_e;
  typedef enum logic [1:0] {
    RS_READY = 2'd0, RS_BUSY = 2'd1, RS_CANT = 2'd2, RS_INC = 2'd3
  } resp_e;
  typedef enum logic [2:0] {
    RC_OK = 3'd0, RC_UNDEF = 3'd1, RC_CPABORT = 3'd2, RC_DABORT = 3'd3, RC_INTR = 3'd4
  } res_e;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0, SRC_RESET = 2'd1, SRC_FIQ = 2'd2, SRC_IRQ = 2'd3
  } src_e;
  typedef enum logic [1:0] {
    CY_NONE = 2'd0, CY_IDLE = 2'd1, CY_COP = 2'd2, CY_MEM = 2'd3
  } cyc_e;
endpackage

// File: rtl/cop_seq_irq_prio.sv
module cop_seq_irq_prio
  import cop_seq_pkg::*;
(
  input  logic       ext_rst_n,
  input  logic       fiq_n,
  input  logic       irq_n,
  input  logic       fiq_mask,
  input  logic       irq_mask,
  output logic       pending,
  output logic [1:0] src
);
  always_comb begin
    pending = 1'b1;
    src     = SRC_NONE;
    if (!ext_rst_n)                src = SRC_RESET;
    else if (!fiq_n && !fiq_mask)  src = SRC_FIQ;
    else if (!irq_n && !irq_mask)  src = SRC_IRQ;
    else                           pending = 1'b0;
  end
endmodule

// File: rtl/cop_seq_addr_chk.sv
module cop_seq_addr_chk #(
  parameter int ADDR_W     = 32,
  parameter int LEGAL_BITS = 26,
  parameter int VEC_BYTES  = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              addr_exc,
  output logic              vec_hit
);
  generate
    if (LEGAL_BITS >= ADDR_W) begin : g_no_limit
      assign addr_exc = 1'b0;
    end else begin : g_limit
      assign addr_exc = |addr[ADDR_W-1:LEGAL_BITS];
    end
  endgenerate
  assign vec_hit = addr < ADDR_W'(VEC_BYTES);
endmodule

// File: rtl/cop_seq.sv
module cop_seq
  import cop_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CP_COUNT   = 16,
  parameter int LEGAL_BITS = 26,
  parameter int VEC_BYTES  = 32,
  localparam int CPN_W     = $clog2(CP_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [CPN_W-1:0]  cmd_cpnum,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [CP_COUNT-1:0] access_mask,
  input  logic              ext_rst_n,
  input  logic              fiq_n,
  input  logic              irq_n,
  input  logic              fiq_mask,
  input  logic              irq_mask,
  output logic              cp_valid,
  output logic [2:0]        cp_phase,
  output logic [CPN_W-1:0]  cp_num,
  output logic [DATA_W-1:0] cp_wdata,
  input  logic [1:0]        cp_resp,
  input  logic [DATA_W-1:0] cp_rdata,
  output logic              mem_req,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_abort,
  output logic [1:0]        cyc_kind,
  output logic              res_valid,
  output logic [2:0]        res_code,
  output logic [1:0]        res_src,
  output logic [DATA_W-1:0] res_rdata
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

  typedef enum logic [3:0] {
    S_IDLE, S_QUERY, S_WAIT, S_INTQ, S_CCYC, S_ICYC,
    S_XFER, S_LMEM, S_LDATA, S_SDATA, S_SMEM
  } state_e;

  state_e            st;
  logic [2:0]        op_q;
  logic [CPN_W-1:0]  cpn_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] word_to_cp_q;
  logic [DATA_W-1:0] word_to_mem_q;
  logic [DATA_W-1:0] rd_q;
  logic              first_q;
  logic              more_q;
  logic              fault_q;
  logic [1:0]        src_q;

  logic       int_pend;
  logic [1:0] int_src;
  logic       a_exc, a_vec;
  logic       is_ldst_in, is_st_in, is_ldst_q;

  cop_seq_irq_prio u_prio (
    .ext_rst_n(ext_rst_n), .fiq_n(fiq_n), .irq_n(irq_n),
    .fiq_mask(fiq_mask), .irq_mask(irq_mask),
    .pending(int_pend), .src(int_src)
  );

  cop_seq_addr_chk #(.ADDR_W(ADDR_W), .LEGAL_BITS(LEGAL_BITS), .VEC_BYTES(VEC_BYTES)) u_achk (
    .addr(cmd_addr), .addr_exc(a_exc), .vec_hit(a_vec)
  );

  assign is_ldst_in = (cmd_op == OP_LOAD) || (cmd_op == OP_STORE);
  assign is_st_in   = (cmd_op == OP_STORE);
  assign is_ldst_q  = (op_q == OP_LOAD) || (op_q == OP_STORE);

  // Port-side decode of the current state
  assign cmd_ready = (st == S_IDLE);
  assign cp_valid  = (st == S_QUERY) || (st == S_INTQ) || (st == S_XFER) ||
                     (st == S_LDATA) || (st == S_SDATA);
  assign cp_num    = cpn_q;
  assign cp_wdata  = word_to_cp_q;
  assign mem_req   = (st == S_LMEM) || (st == S_SMEM);
  assign mem_we    = (st == S_SMEM);
  assign mem_addr  = addr_q;
  assign mem_wdata = word_to_mem_q;

  always_comb begin
    case (st)
      S_QUERY: cp_phase = first_q ? PH_FIRST : PH_BUSY;
      S_INTQ:  cp_phase = PH_INT;
      S_XFER:  cp_phase = PH_XFER;
      default: cp_phase = PH_DATA;
    endcase
    case (st)
      S_WAIT, S_ICYC: cyc_kind = CY_IDLE;
      S_CCYC:         cyc_kind = CY_COP;
      S_LMEM, S_SMEM: cyc_kind = CY_MEM;
      default:        cyc_kind = CY_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      op_q          <= '0;
      cpn_q         <= '0;
      addr_q        <= '0;
      word_to_cp_q  <= '0;
      word_to_mem_q <= '0;
      rd_q          <= '0;
      first_q       <= 1'b0;
      more_q        <= 1'b0;
      fault_q       <= 1'b0;
      src_q         <= SRC_NONE;
      res_valid     <= 1'b0;
      res_code      <= RC_OK;
      res_src       <= SRC_NONE;
      res_rdata     <= '0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_q         <= cmd_op;
          cpn_q        <= cmd_cpnum;
          addr_q       <= cmd_addr;
          word_to_cp_q <= cmd_wdata;
          first_q      <= 1'b1;
          rd_q         <= '0;
          fault_q      <= (is_ldst_in && a_exc) || (is_st_in && a_vec);
          if (!access_mask[cmd_cpnum]) begin
            res_valid <= 1'b1;
            res_code  <= RC_UNDEF;
            res_src   <= SRC_NONE;
            res_rdata <= '0;
          end else begin
            st <= S_QUERY;
          end
        end
        S_QUERY: begin
          first_q <= 1'b0;
          if (cp_resp == RS_BUSY) begin
            st <= S_WAIT;
          end else if (cp_resp == RS_CANT) begin
            st        <= S_IDLE;
            res_valid <= 1'b1;
            res_code  <= is_ldst_q ? RC_CPABORT : RC_UNDEF;
            res_src   <= SRC_NONE;
            res_rdata <= '0;
          end else begin
            case (op_q)
              OP_TO_CP:   st <= S_CCYC;
              OP_FROM_CP: begin rd_q <= cp_rdata; st <= S_CCYC; end
              OP_LOAD:    st <= S_XFER;
              OP_STORE:   st <= S_SDATA;
              default: begin
                st        <= S_IDLE;
                res_valid <= 1'b1;
                res_code  <= RC_OK;
                res_src   <= SRC_NONE;
                res_rdata <= '0;
              end
            endcase
          end
        end
        S_WAIT: begin
          src_q <= int_src;
          st    <= int_pend ? S_INTQ : S_QUERY;
        end
        S_INTQ: begin
          st        <= S_IDLE;
          res_valid <= 1'b1;
          res_code  <= RC_INTR;
          res_src   <= src_q;
          res_rdata <= '0;
        end
        S_CCYC: begin
          if (op_q == OP_FROM_CP) begin
            st <= S_ICYC;
          end else begin
            st        <= S_IDLE;
            res_valid <= 1'b1;
            res_code  <= RC_OK;
            res_src   <= SRC_NONE;
            res_rdata <= '0;
          end
        end
        S_ICYC: begin
          st        <= S_IDLE;
          res_valid <= 1'b1;
          res_code  <= RC_OK;
          res_src   <= SRC_NONE;
          res_rdata <= rd_q;
        end
        S_XFER: st <= S_LMEM;
        S_LMEM: if (mem_ready) begin
          word_to_cp_q <= mem_rdata;
          fault_q      <= fault_q | mem_abort;
          st           <= S_LDATA;
        end
        S_LDATA: begin
          if (cp_resp == RS_INC) begin
            addr_q <= addr_q + WORD_STEP;
            st     <= S_LMEM;
          end else begin
            st        <= S_IDLE;
            res_valid <= 1'b1;
            res_code  <= fault_q ? RC_DABORT : RC_OK;
            res_src   <= SRC_NONE;
            res_rdata <= '0;
          end
        end
        S_SDATA: begin
          word_to_mem_q <= cp_rdata;
          more_q        <= (cp_resp == RS_INC);
          st            <= S_SMEM;
        end
        S_SMEM: if (mem_ready) begin
          fault_q <= fault_q | mem_abort;
          if (more_q) begin
            addr_q <= addr_q + WORD_STEP;
            st     <= S_SDATA;
          end else begin
            st        <= S_IDLE;
            res_valid <= 1'b1;
            res_code  <= (fault_q || mem_abort) ? RC_DABORT : RC_OK;
            res_src   <= SRC_NONE;
            res_rdata <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cop_seq_chk.sv
module cop_seq_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int CP_COUNT = 16,
  parameter int CPN_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [CPN_W-1:0]  cmd_cpnum,
  input logic [CP_COUNT-1:0] access_mask,
  input logic              cp_valid,
  input logic [2:0]        cp_phase,
  input logic [1:0]        cp_resp,
  input logic              mem_req,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        cyc_kind,
  input logic              res_valid,
  input logic [2:0]        res_code,
  input logic [DATA_W-1:0] res_rdata
);
  logic              seen_q;
  logic [ADDR_W-1:0] last_q;

  p_deny_undef_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !access_mask[cmd_cpnum] |=> res_valid && res_code == 3'd1 && !cp_valid);

  p_first_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && access_mask[cmd_cpnum] |=> cp_valid && cp_phase == 3'd0);

  p_busy_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid && (cp_phase == 3'd0 || cp_phase == 3'd1) && cp_resp == 2'd1 |=> !cp_valid && cyc_kind == 2'd1);

  p_int_abandon_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid && cp_phase == 3'd2 |=> res_valid && res_code == 3'd4 && res_rdata == '0);

  p_cant_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid && (cp_phase == 3'd0 || cp_phase == 3'd1) && cp_resp == 2'd2 |=>
      res_valid && (res_code == 3'd1 || res_code == 3'd2) && !mem_req);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (cmd_valid && cmd_ready) begin
      seen_q <= 1'b0;
    end else if (mem_req && mem_ready) begin
      p_addr_step_r6: assert (!seen_q || mem_addr == last_q + ADDR_W'(4))
        else $error("word address did not advance by 4");
      seen_q <= 1'b1;
      last_q <= mem_addr;
    end
  end
endmodule

bind cop_seq cop_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CP_COUNT(CP_COUNT), .CPN_W(CPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_cpnum(cmd_cpnum), .access_mask(access_mask), .cp_valid(cp_valid),
  .cp_phase(cp_phase), .cp_resp(cp_resp), .mem_req(mem_req), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .cyc_kind(cyc_kind), .res_valid(res_valid),
  .res_code(res_code), .res_rdata(res_rdata)
);

// File: tb/cop_seq_tb_top.sv
module cop_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [3:0]  cmd_cpnum = '0;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic [15:0] access_mask = '1;
  logic        ext_rst_n = 1'b1, fiq_n = 1'b1, irq_n = 1'b1, fiq_mask = 1'b0, irq_mask = 1'b0;
  logic        cp_valid;
  logic [2:0]  cp_phase;
  logic [3:0]  cp_num;
  logic [31:0] cp_wdata;
  logic [1:0]  cp_resp;
  logic [31:0] cp_rdata;
  logic        mem_req, mem_ready, mem_we, mem_abort;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  cyc_kind;
  logic        res_valid;
  logic [2:0]  res_code;
  logic [1:0]  res_src;
  logic [31:0] res_rdata;

  cop_seq dut_i (.*);

  // coprocessor and memory models
  int          busy_left = 0, inc_left = 0, sidx = 0, mwait = 0, mstall = 0;
  logic [1:0]  final_resp = 2'd0;
  logic [31:0] abort_addr = 32'h3;

  always_comb begin
    if (cp_phase == 3'd0 || cp_phase == 3'd1) cp_resp = (busy_left > 0) ? 2'd1 : final_resp;
    else if (cp_phase == 3'd4)                cp_resp = (inc_left > 0) ? 2'd3 : 2'd0;
    else                                      cp_resp = 2'd0;
    cp_rdata = (cp_phase == 3'd4) ? 32'hA000_0000 + 32'(sidx) : (32'h5A5A_0000 | 32'(cp_num));
  end
  assign mem_ready = (mwait == mstall);
  assign mem_rdata = ~mem_addr;
  assign mem_abort = mem_req && (mem_addr == abort_addr);

  always @(posedge clk) begin
    if (cp_valid && (cp_phase == 3'd0 || cp_phase == 3'd1) && busy_left > 0) busy_left <= busy_left - 1;
    if (cp_valid && cp_phase == 3'd4) begin
      sidx <= sidx + 1;
      if (inc_left > 0) inc_left <= inc_left - 1;
    end
    if (mem_req && !mem_ready) mwait <= mwait + 1; else mwait <= 0;
  end

  int n_chk = 0, n_fail = 0, cycles = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor, sampled at the falling edge
  int nfirst, nbusy, nint, nxfer, ndata, nc, ni, nmem;
  logic [2:0]  e_op;
  logic [31:0] e_a0, e_w;
  bit          prev_stall = 0;
  logic [31:0] prev_addr = '0;
  always @(negedge clk) begin
    cycles++;
    if (cp_valid) begin
      case (cp_phase)
        3'd0: begin
          nfirst++;
          if (e_op == 3'd0) chk(cp_wdata == e_w, "R2 write data", cp_wdata, e_w);
        end
        3'd1: nbusy++;
        3'd2: nint++;
        3'd3: nxfer++;
        default: begin
          if (e_op == 3'd3) chk(cp_wdata == ~(e_a0 + 32'(4*ndata)), "R6 load word", cp_wdata, ~(e_a0 + 32'(4*ndata)));
          ndata++;
        end
      endcase
    end
    if (cyc_kind == 2'd1) ni++;
    if (cyc_kind == 2'd2) nc++;
    if (prev_stall) chk(mem_req && mem_addr == prev_addr, "R11 held request", mem_addr, prev_addr);
    if (mem_req && mem_ready) begin
      chk(mem_addr == e_a0 + 32'(4*nmem), "R6/R7 address", mem_addr, e_a0 + 32'(4*nmem));
      if (mem_we) chk(mem_wdata == 32'hA000_0000 + 32'(nmem), "R7 store word", mem_wdata, 32'hA000_0000 + 32'(nmem));
      nmem++;
    end
    prev_stall = mem_req && !mem_ready;
    prev_addr  = mem_addr;
  end

  task automatic run(input int op, input int cp, input logic [31:0] a0, input int busy,
                     input logic [1:0] fin, input int inc, input int stall,
                     input logic [4:0] irqs, input logic [15:0] mask, input logic [31:0] ab);
    int e_code, e_src, e_first, e_busy, e_int, e_c, e_i, e_mem;
    logic [31:0] e_rd;
    bit allowed, pend, ldst, dab;
    int wait_cnt;
    @(negedge clk);
    {ext_rst_n, fiq_n, irq_n, fiq_mask, irq_mask} = irqs;
    access_mask = mask; abort_addr = ab;
    busy_left = busy; inc_left = inc; sidx = 0; mstall = stall; final_resp = fin;
    nfirst = 0; nbusy = 0; nint = 0; nxfer = 0; ndata = 0; nc = 0; ni = 0; nmem = 0;
    e_op = 3'(op); e_a0 = a0; e_w = 32'hC0DE_0000 + 32'(op*16 + busy);
    cmd_op = 3'(op); cmd_cpnum = 4'(cp); cmd_addr = a0; cmd_wdata = e_w; cmd_valid = 1'b1;
    chk(cmd_ready == 1'b1, "R11 ready when idle", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_cnt = 0;
    while (!res_valid && wait_cnt < 300) begin @(negedge clk); wait_cnt++; end
    chk(wait_cnt < 300, "R2 completion", wait_cnt, 0);
    // expected outcome
    allowed = mask[cp];
    ldst = (op == 3 || op == 4);
    pend = !irqs[4] || (!irqs[3] && !irqs[1]) || (!irqs[2] && !irqs[0]);
    e_src = !irqs[4] ? 1 : (!irqs[3] && !irqs[1]) ? 2 : (!irqs[2] && !irqs[0]) ? 3 : 0;
    e_first = 0; e_busy = 0; e_int = 0; e_c = 0; e_i = 0; e_mem = 0; e_rd = 0;
    if (!allowed) begin
      e_code = 1; e_src = 0;
    end else if (busy > 0 && pend) begin
      e_code = 4; e_first = 1; e_int = 1; e_i = 1;
    end else begin
      e_src = 0; e_first = 1; e_busy = busy; e_i = busy;
      if (fin == 2'd2) e_code = ldst ? 2 : 1;
      else if (ldst) begin
        e_mem = inc + 1;
        dab = (a0[31:26] != 0) || (op == 4 && a0 < 32);
        for (int k = 0; k <= inc; k++) if (a0 + 32'(4*k) == ab) dab = 1;
        e_code = dab ? 3 : 0;
      end else begin
        e_code = 0;
        if (op == 0) e_c = 1;
        if (op == 1) begin e_c = 1; e_i = busy + 1; e_rd = 32'h5A5A_0000 | 32'(cp); end
      end
    end
    chk(res_code == 3'(e_code), "R1/R3/R5/R8/R9 code", res_code, e_code);
    chk(res_src == 2'(e_src), "R4 source", res_src, e_src);
    chk(res_rdata == e_rd, "R10 read result", res_rdata, e_rd);
    chk(nfirst == e_first, "R1/R2 first queries", nfirst, e_first);
    chk(nbusy == e_busy, "R2 busy queries", nbusy, e_busy);
    chk(nint == e_int, "R3 interrupt queries", nint, e_int);
    chk(nc == e_c, "R10 coprocessor cycles", nc, e_c);
    chk(ni == e_i, "R2/R10 idle cycles", ni, e_i);
    chk(nmem == e_mem, "R6/R7 word count", nmem, e_mem);
    if (op == 3 && e_mem > 0) chk(nxfer == 1, "R6 transfer phase", nxfer, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(res_valid == 0 && cp_valid == 0 && mem_req == 0, "R11 reset state", {res_valid, cp_valid, mem_req}, 0);
    rst_n = 1'b1;
    // main sweep
    for (int op = 0; op < 5; op++)
      for (int b = 0; b < 3; b++)
        for (int f = 0; f < 2; f++)
          for (int inc = 0; inc < ((op >= 3) ? 3 : 1); inc++)
            run(op, op + 3, 32'h0000_1000 + 32'(64*inc), b, f ? 2'd2 : 2'd0, inc, (b + inc) % 3,
                5'b11100, 16'hFFFF, 32'h3);
    // R1 denied coprocessor
    run(1, 5, 32'h100, 1, 2'd0, 0, 0, 5'b11100, 16'hFFDF, 32'h3);
    run(3, 9, 32'h100, 0, 2'd0, 1, 0, 5'b11100, 16'h0200 ^ 16'hFFFF, 32'h3);
    // R3 / R4 interrupt line sweep
    for (int v = 0; v < 32; v++) run(1, 2, 32'h100, 2, 2'd0, 0, 0, 5'(v), 16'hFFFF, 32'h3);
    // R8 address checks
    run(3, 1, 32'h0400_0000, 0, 2'd0, 1, 1, 5'b11100, 16'hFFFF, 32'h3);
    run(4, 1, 32'h0000_0010, 1, 2'd0, 1, 0, 5'b11100, 16'hFFFF, 32'h3);
    run(3, 1, 32'h0000_0010, 1, 2'd0, 1, 0, 5'b11100, 16'hFFFF, 32'h3);
    // R9 memory abort on a middle word
    run(4, 1, 32'h0000_2000, 0, 2'd0, 2, 2, 5'b11100, 16'hFFFF, 32'h0000_2004);
    run(3, 1, 32'h0000_2000, 0, 2'd0, 2, 0, 5'b11100, 16'hFFFF, 32'h0000_2008);
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule